// File: doc/BRIEF.md
# Script Register Arithmetic Unit

This unit carries out the byte-wide register instructions of a small script engine. It holds a byte-addressed register space and one working byte register, called SFBR. Each 32-bit instruction word arrives over a valid/ready handshake. The unit decodes the word and computes one 8-bit operation. It then writes the result back to the addressed register or to SFBR, and it keeps a carry flag.

Three instruction forms place SFBR and the addressed register in different roles:

- One form writes SFBR combined with the operand into the register.
- One form writes the register combined with the operand into SFBR.
- One form updates the register in place from its own value.

Several common actions are special cases of these forms:

- Copying a register into SFBR is the SFBR-destination form with OR and an operand of zero.
- Copying SFBR into a register is the register-destination form that takes SFBR, with OR and an operand of zero.
- SFBR receives an immediate through the SFBR-destination form with the load operation, pointed at offset 0x07.

Each accepted instruction finishes in the next cycle. A one-cycle completion pulse reports the destination and the value written. The rest of the script engine uses this pulse to retire the instruction and to watch register traffic.

Top module: `regop_unit`

## Requirements
- R1: A word with bits 31:27 = 5'b01111 sets register[offset] = register[offset] op operand. SFBR is left unchanged.
- R2: A word with bits 31:27 = 5'b01101 sets register[offset] = SFBR op operand. SFBR is left unchanged.
- R3: A word with bits 31:27 = 5'b01110 sets SFBR = register[offset] op operand. No register in the space changes.
- R4: Bits 26:24 choose the operation, where the first operand is the source named in R1 to R3 and the second is the data operand:
  - 0 loads the data operand itself.
  - 2 gives the bitwise OR of the two operands.
  - 3 gives the bitwise XOR of the two operands.
  - 4 gives the bitwise AND of the two operands.
  - These four operations leave the carry flag unchanged.
- R5: Operation 1 shifts the source left, fills bit 0 with 0 and copies the old bit 7 to carry. Operation 5 shifts the source right, fills bit 7 with 0 and copies the old bit 0 to carry.
- R6: Operation 6 adds source and operand modulo 256 and sets carry to the carry-out. Operation 7 does the same and also adds the current carry flag as carry-in.
- R7: The data operand is the immediate in bits 15:8 when bit 23 is 0. When bit 23 is 1 it is the current SFBR value, and the immediate is ignored.
- R8: The register offset is {bit 7, bits 22:16} of the word. Offsets 0x80 to 0xFF reach registers distinct from offsets 0x00 to 0x7F.
- R9: `in_ready` is high whenever reset is not asserted. An accepted legal word raises `done_o` for exactly the next cycle, together with:
  - `done_to_sfbr_o` (1 when SFBR was the destination);
  - `done_off_o`, the decoded offset;
  - `done_val_o`, the value written.

  A word issued in the cycle after another sees the first one's result. `done_o` is low in every other cycle.
- R10: Reset clears SFBR, the carry flag, `done_o` and every byte of the register space to zero.
- R11: An accepted word whose bits 31:27 match none of the three forms produces no completion pulse. It changes no register, SFBR or carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit accepts a word this cycle |
| in_instr | input | 32 | Instruction word |
| done_o | output | 1 | One-cycle completion pulse |
| done_to_sfbr_o | output | 1 | Completed instruction wrote SFBR (else a register) |
| done_off_o | output | 8 | Register offset of the completed instruction |
| done_val_o | output | 8 | Value written by the completed instruction |
| sfbr_o | output | 8 | Current SFBR contents |
| carry_o | output | 1 | Current carry flag |

## Verification
The bench sweeps every operation across all three forms, with a grid of source and operand values and both carry states. This exposes a form that routes SFBR and the register the wrong way round. It also exposes an add-with-carry that ignores carry-in, or a logic operation that disturbs carry.

The bench writes distinct values at offsets that differ only in bit 7, which catches an offset decode that drops the scattered high bit. It sets bit 23 with a deliberately wrong immediate, so a unit that ignores the SFBR-operand select returns a visibly different value.

Two dependent words are issued back to back; a stale read or a one-cycle-late writeback shows up there. Illegal words and a mid-run reset are followed by read-backs, which catch stray writes and registers that survive reset.

// File: rtl/regop_pkg.sv
package regop_pkg;

    localparam int DATA_W  = 8;
    localparam int OFF_W   = 8;
    localparam int INSTR_W = 32;

    localparam logic [4:0] CLS_SFBR_TO_REG = 5'b01101;
    localparam logic [4:0] CLS_REG_TO_SFBR = 5'b01110;
    localparam logic [4:0] CLS_REG_TO_REG  = 5'b01111;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_SHL  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_AND  = 3'd4,
        OP_SHR  = 3'd5,
        OP_ADD  = 3'd6,
        OP_ADDC = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        FORM_NONE      = 2'd0,
        FORM_SFBR_SRC  = 2'd1,
        FORM_SFBR_DST  = 2'd2,
        FORM_REG_REG   = 2'd3
    } form_e;

    typedef struct packed {
        logic              legal;
        form_e             form;
        alu_op_e           op;
        logic [OFF_W-1:0]  off;
        logic              use_sfbr;
        logic [DATA_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cout;
        logic              cwe;
    } alu_out_t;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] sfbr;
        logic              carry;
        logic              done;
        logic              done_sfbr;
        logic [OFF_W-1:0]  done_off;
        logic [DATA_W-1:0] done_val;
    } unit_st_t;

endpackage

// File: rtl/regop_decode.sv
module regop_decode
    import regop_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);
    logic [4:0] cls;
    logic       unused_low;

    assign cls        = word[31:27];
    assign unused_low = ^word[6:0];

    always_comb begin
        dec          = '0;
        dec.op       = alu_op_e'(word[26:24]);
        dec.use_sfbr = word[23];
        dec.off      = {word[7], word[22:16]};
        dec.imm      = word[15:8];
        unique case (cls)
            CLS_SFBR_TO_REG: begin dec.form = FORM_SFBR_SRC; dec.legal = 1'b1; end
            CLS_REG_TO_SFBR: begin dec.form = FORM_SFBR_DST; dec.legal = 1'b1; end
            CLS_REG_TO_REG:  begin dec.form = FORM_REG_REG;  dec.legal = 1'b1; end
            default:         begin dec.form = FORM_NONE;     dec.legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/regop_alu.sv
module regop_alu
    import regop_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         cwe
);
    logic [W:0] sum;
    logic       cin_eff;

    assign cin_eff = (op == OP_ADDC) & cin;
    assign sum     = {1'b0, src_a} + {1'b0, src_b} + {{W{1'b0}}, cin_eff};

    always_comb begin
        res  = '0;
        cout = 1'b0;
        cwe  = 1'b0;
        unique case (op)
            OP_LOAD: res = src_b;
            OP_OR:   res = src_a | src_b;
            OP_XOR:  res = src_a ^ src_b;
            OP_AND:  res = src_a & src_b;
            OP_SHL: begin
                res  = {src_a[W-2:0], 1'b0};
                cout = src_a[W-1];
                cwe  = 1'b1;
            end
            OP_SHR: begin
                res  = {1'b0, src_a[W-1:1]};
                cout = src_a[0];
                cwe  = 1'b1;
            end
            OP_ADD, OP_ADDC: begin
                res  = sum[W-1:0];
                cout = sum[W];
                cwe  = 1'b1;
            end
            default: res = src_b;
        endcase
    end

endmodule

// File: rtl/regop_regfile.sv
module regop_regfile
    import regop_pkg::*;
#(
    parameter int NUM_REGS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        logic [DATA_W-1:0] ent_d, ent_q;
        logic              hit;

        assign hit = wr_en && (wr_off == OFF_W'(g));

        always_comb begin
            ent_d = ent_q;
            if (hit) ent_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign mem_q[g] = ent_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_off == OFF_W'(i)) rd_data = mem_q[i];
        end
    end

endmodule

// File: rtl/regop_unit.sv
module regop_unit
    import regop_pkg::*;
#(
    parameter int NUM_REGS = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               done_o,
    output logic               done_to_sfbr_o,
    output logic [OFF_W-1:0]   done_off_o,
    output logic [DATA_W-1:0]  done_val_o,
    output logic [DATA_W-1:0]  sfbr_o,
    output logic               carry_o
);
    unit_st_t          st_d, st_q;
    dec_t              dec;
    logic [DATA_W-1:0] reg_rd;
    logic [DATA_W-1:0] alu_a, alu_b, alu_res;
    logic              alu_cout, alu_cwe;
    logic              accept;
    logic              rf_we;

    regop_decode u_dec (
        .word (in_instr),
        .dec  (dec)
    );

    regop_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_off  (dec.off),
        .rd_data (reg_rd),
        .wr_en   (rf_we),
        .wr_off  (dec.off),
        .wr_data (alu_res)
    );

    assign alu_a = (dec.form == FORM_SFBR_SRC) ? st_q.sfbr : reg_rd;
    assign alu_b = dec.use_sfbr ? st_q.sfbr : dec.imm;

    regop_alu #(.W(DATA_W)) u_alu (
        .src_a (alu_a),
        .src_b (alu_b),
        .cin   (st_q.carry),
        .op    (dec.op),
        .res   (alu_res),
        .cout  (alu_cout),
        .cwe   (alu_cwe)
    );

    assign accept = in_valid && st_q.ready;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.done  = 1'b0;
        rf_we      = 1'b0;
        if (accept && dec.legal) begin
            st_d.done      = 1'b1;
            st_d.done_sfbr = (dec.form == FORM_SFBR_DST);
            st_d.done_off  = dec.off;
            st_d.done_val  = alu_res;
            if (alu_cwe) st_d.carry = alu_cout;
            if (dec.form == FORM_SFBR_DST) st_d.sfbr = alu_res;
            else                           rf_we     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready       = st_q.ready;
    assign done_o         = st_q.done;
    assign done_to_sfbr_o = st_q.done_sfbr;
    assign done_off_o     = st_q.done_off;
    assign done_val_o     = st_q.done_val;
    assign sfbr_o         = st_q.sfbr;
    assign carry_o        = st_q.carry;

    // R9: accepted legal word completes in the next cycle
    p_done_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dec.legal) |=> done_o);

    // R9: no completion without an accepted word
    p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !done_o);

    // R11: illegal word leaves visible state alone
    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !dec.legal) |=> (!done_o && $stable(sfbr_o) && $stable(carry_o)));

    // R1/R2: register destination never moves SFBR
    p_reg_dest_keeps_sfbr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !done_to_sfbr_o) |-> $stable(sfbr_o));

    // R3: SFBR destination holds the reported value
    p_sfbr_dest_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_to_sfbr_o) |-> (sfbr_o == done_val_o));

    // R4: load and logic operations keep carry
    p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.legal && (dec.op inside {OP_LOAD, OP_OR, OP_XOR, OP_AND})) |=> $stable(carry_o));

    // R5: shift left moves source bit 7 into carry
    p_shl_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.legal && dec.op == OP_SHL) |=> (carry_o == $past(alu_a[DATA_W-1])));

    // R5: shift right moves source bit 0 into carry
    p_shr_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.legal && dec.op == OP_SHR) |=> (carry_o == $past(alu_a[0])));

endmodule

// File: tb/sim_regop_unit.sv
module sim_regop_unit;

    localparam logic [4:0] F_S2R = 5'b01101;
    localparam logic [4:0] F_R2S = 5'b01110;
    localparam logic [4:0] F_R2R = 5'b01111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        done_o, done_to_sfbr_o, carry_o;
    logic [7:0]  done_off_o, done_val_o, sfbr_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_regs [256];
    logic [7:0] m_sfbr;
    logic       m_carry;

    always #5 clk = ~clk;

    regop_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .done_o(done_o), .done_to_sfbr_o(done_to_sfbr_o),
        .done_off_o(done_off_o), .done_val_o(done_val_o), .sfbr_o(sfbr_o),
        .carry_o(carry_o)
    );

    function automatic logic [31:0] mk(input logic [4:0] f, input int op,
                                       input logic [7:0] off, input logic [7:0] imm,
                                       input logic usf);
        return {f, 3'(op), usf, off[6:0], imm, off[7], 7'b0};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
        m_sfbr  = 8'h00;
        m_carry = 1'b0;
    endtask

    task automatic model(input logic [31:0] w, output logic ev, output logic es,
                         output logic [7:0] eo, output logic [7:0] evl);
        logic [4:0] f;
        logic [7:0] a, b, r;
        logic [8:0] s;
        f   = w[31:27];
        eo  = {w[7], w[22:16]};
        ev  = (f == F_S2R) || (f == F_R2S) || (f == F_R2R);
        es  = (f == F_R2S);
        evl = 8'h00;
        if (ev) begin
            b = w[23] ? m_sfbr : w[15:8];
            a = (f == F_S2R) ? m_sfbr : m_regs[eo];
            case (w[26:24])
                3'd0: r = b;
                3'd1: begin r = {a[6:0], 1'b0}; m_carry = a[7]; end
                3'd2: r = a | b;
                3'd3: r = a ^ b;
                3'd4: r = a & b;
                3'd5: begin r = {1'b0, a[7:1]}; m_carry = a[0]; end
                3'd6: begin s = a + b; r = s[7:0]; m_carry = s[8]; end
                default: begin s = a + b + m_carry; r = s[7:0]; m_carry = s[8]; end
            endcase
            evl = r;
            if (es) m_sfbr = r;
            else    m_regs[eo] = r;
        end
    endtask

    task automatic cmp(input string tag, input logic [31:0] w, input logic ev,
                       input logic es, input logic [7:0] eo, input logic [7:0] evl);
        logic ok;
        n_tests++;
        if (ev) ok = done_o && (done_to_sfbr_o == es) && (done_off_o == eo) && (done_val_o == evl);
        else    ok = !done_o;
        ok = ok && (sfbr_o == m_sfbr) && (carry_o == m_carry);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s word=%h actual done=%b tosfbr=%b off=%h val=%h sfbr=%h c=%b expected done=%b tosfbr=%b off=%h val=%h sfbr=%h c=%b",
                     tag, w, done_o, done_to_sfbr_o, done_off_o, done_val_o, sfbr_o, carry_o,
                     ev, es, eo, evl, m_sfbr, m_carry);
        end
    endtask

    task automatic run(input logic [31:0] w, input string tag);
        logic ev, es;
        logic [7:0] eo, evl;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = w;
        model(w, ev, es, eo, evl);
        @(negedge clk);
        in_valid = 1'b0;
        cmp(tag, w, ev, es, eo, evl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] a, b, t;
        logic ev1, es1, ev2, es2;
        logic [7:0] eo1, ev1l, eo2, ev2l;
        string otag [8];
        otag = '{"R4 load", "R5 shl", "R4 or", "R4 xor", "R4 and", "R5 shr", "R6 add", "R6 addc"};

        // R10: reset state
        model_clear();
        repeat (2) @(negedge clk);
        check_bit("R10 done low in reset", done_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R9 ready after reset", in_ready, 1'b1);
        check_bit("R10 carry clear", carry_o, 1'b0);
        for (int i = 0; i < 256; i++) run(mk(F_R2S, 2, 8'(i), 8'h00, 1'b0), "R10 register cleared");

        // R8: offsets that differ only in bit 7
        run(mk(F_R2R, 0, 8'h05, 8'hA5, 1'b0), "R8 low write");
        run(mk(F_R2R, 0, 8'h85, 8'h3C, 1'b0), "R8 high write");
        run(mk(F_R2S, 2, 8'h05, 8'h00, 1'b0), "R8 low readback");
        run(mk(F_R2S, 2, 8'h85, 8'h00, 1'b0), "R8 high readback");
        run(mk(F_R2S, 2, 8'hFF, 8'h00, 1'b0), "R8 top offset");

        // R3 load SFBR immediate via offset 7; R2 copy SFBR to register
        run(mk(F_R2S, 0, 8'h07, 8'h5A, 1'b0), "R3 load sfbr immediate");
        run(mk(F_S2R, 2, 8'h90, 8'h00, 1'b0), "R2 copy sfbr to reg");
        run(mk(F_R2S, 2, 8'h90, 8'h00, 1'b0), "R3 copy reg to sfbr");

        // R1..R7 sweep over forms, operations, values and carry
        for (int op = 0; op < 8; op++) begin
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    for (int c = 0; c < 2; c++) begin
                        int fsel;
                        logic usf;
                        a = 8'((ai * 16) | ((ai * 7) & 15));
                        b = 8'((bi * 16) | ((15 - bi) & 15));
                        t = 8'((c * 128) | (bi * 8) | (ai % 8));
                        fsel = (ai + bi + op) % 3;
                        usf = (((ai ^ bi) & 3) == 0);
                        run(mk(F_R2R, 0, 8'h40, (c != 0) ? 8'h80 : 8'h00, 1'b0), "R4 carry preset load");
                        run(mk(F_R2R, 1, 8'h40, 8'h00, 1'b0), "R5 carry preset shl");
                        if (fsel == 1) run(mk(F_R2S, 0, 8'h07, a, 1'b0), "R3 sfbr preset");
                        else           run(mk(F_R2R, 0, t, a, 1'b0), "R1 reg preset");
                        if (usf && fsel != 1) run(mk(F_R2S, 0, 8'h07, b, 1'b0), "R7 sfbr operand preset");
                        case (fsel)
                            0: run(mk(F_R2R, op, t, usf ? ~b : b, usf), {"R1 R7 ", otag[op]});
                            1: run(mk(F_S2R, op, t, usf ? ~b : b, usf), {"R2 R7 ", otag[op]});
                            default: begin
                                run(mk(F_R2S, op, t, usf ? ~b : b, usf), {"R3 R7 ", otag[op]});
                                run(mk(F_R2S, 2, t, 8'h00, 1'b0), "R3 register untouched");
                            end
                        endcase
                    end
                end
            end
        end

        // R11: illegal words
        run(mk(F_R2R, 0, 8'h33, 8'h77, 1'b0), "R11 setup");
        run(32'h6033_7700, "R11 illegal 0x60");
        run(32'h8033_7780, "R11 illegal 0x80");
        run(32'h4233_7700, "R11 illegal 0x42");
        run(32'hE133_0000, "R11 illegal 0xE1");
        run(32'h0033_FF00, "R11 illegal 0x00");
        run(mk(F_R2S, 2, 8'h33, 8'h00, 1'b0), "R11 register unchanged");

        // R9: back to back dependent words
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = mk(F_R2R, 0, 8'h61, 8'h0F, 1'b0);
        model(in_instr, ev1, es1, eo1, ev1l);
        @(negedge clk);
        cmp("R9 first of pair", mk(F_R2R, 0, 8'h61, 8'h0F, 1'b0), ev1, es1, eo1, ev1l);
        in_instr = mk(F_R2S, 6, 8'h61, 8'hF1, 1'b0);
        model(in_instr, ev2, es2, eo2, ev2l);
        @(negedge clk);
        in_valid = 1'b0;
        cmp("R9 second sees first", mk(F_R2S, 6, 8'h61, 8'hF1, 1'b0), ev2, es2, eo2, ev2l);
        @(negedge clk);
        check_bit("R9 done single pulse", done_o, 1'b0);

        // R10: reset mid-run clears everything
        run(mk(F_R2R, 0, 8'hC4, 8'h99, 1'b0), "R10 pre-reset write");
        do_reset();
        @(negedge clk);
        check_bit("R10 carry after reset", carry_o, 1'b0);
        check_bit("R10 done after reset", done_o, 1'b0);
        run(mk(F_R2S, 2, 8'hC4, 8'h00, 1'b0), "R10 register cleared after reset");
        run(mk(F_R2S, 2, 8'h61, 8'h00, 1'b0), "R10 register cleared after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule